// File: doc/BRIEF.md
# Prioritized Pending Interrupt Selector

This block keeps one pending flag per interrupt source and, whenever the core reaches an interrupt boundary and raises its accept strobe, picks the single source to deliver. Sources raise their flag with a one-cycle set pulse. The pick follows a fixed priority ladder. Each source also has its own delivery condition, built from the machine-state bits: external enable, machine-check enable, critical enable, hypervisor state, whether hypervisor mode exists, a hypervisor-decrementer enable and an external-routing control bit. A source whose condition is false does not block lower-priority sources.

On an accepted delivery the block registers the chosen cause, both one-hot and encoded. On the same clock edge it clears the pending flag of the winner, if that source clears on delivery. Level-like sources stay pending until the source itself goes quiet, and the decrementer's behaviour is set by a configuration input. A pending-any output tells the core that service requests remain. Exception entry, vectoring and state save sit outside this block.

Top module: `irq_prio_sel`

## Requirements
- R1: After reset no source is pending: `pend_any` is 0, and `take_vld`, `take_onehot` and `take_code` are all 0.
- R2: On accept, the winner is the eligible pending source with the lowest index in this ladder. The ladder runs 0 system reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 external, 5 critical external, 6 watchdog, 7 critical doorbell, 8 fixed-interval timer, 9 programmable-interval timer, 10 decrementer, 11 doorbell, 12 performance monitor, 13 thermal. A pending source that is not eligible does not block lower sources. `take_onehot` has only bit `take_code` set.
- R3: System reset (0) and debug (2) are always eligible and are cleared when taken.
- R4: Machine check (1) is eligible only when `mchk_en` is 1, and is cleared when taken.
- R5: Hypervisor decrementer (3) is eligible only when `hdec_enable` is 1 and (`ext_en` is 1 or `hv_state` is 0). It is cleared when taken.
- R6: External (4) is eligible when `ext_en` is 1, or when `hv_exists` is 1, `hv_state` is 0 and `ext_hv_route` is 0. It stays pending after it is taken.
- R7: Critical external (5), watchdog (6) and critical doorbell (7) are eligible only when `crit_en` is 1. Source 5 stays pending when taken; sources 6 and 7 are cleared.
- R8: Fixed-interval (8), programmable-interval (9), doorbell (11), performance monitor (12) and thermal (13) are eligible only when `ext_en` is 1, and are cleared when taken.
- R9: Decrementer (10) is eligible only when `ext_en` is 1. It is cleared when taken only if `dec_clear_cfg` is 1.
- R10: A set pulse for a source on the same edge that its delivery clears it leaves that source pending.
- R11: `pend_any` is 1 exactly when at least one source is pending. It rises on the cycle after a set pulse.
- R12: `take_vld` is 1 only on the cycle after an edge where `accept` was 1 and some source was eligible. Otherwise `take_vld`, `take_onehot` and `take_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | N_SRC | Per-source set pulses, bit index = ladder position |
| ext_en | input | 1 | External-enable machine-state bit |
| mchk_en | input | 1 | Machine-check enable |
| crit_en | input | 1 | Critical-class enable |
| hv_state | input | 1 | Core is in hypervisor state |
| hv_exists | input | 1 | Hypervisor mode is implemented |
| hdec_enable | input | 1 | Hypervisor-decrementer enable control bit |
| ext_hv_route | input | 1 | Routes external interrupts to the hypervisor; when 0 a non-hypervisor core may take them with `ext_en` low |
| dec_clear_cfg | input | 1 | Decrementer clears its flag on delivery when 1 |
| accept | input | 1 | Core is at an interrupt boundary and takes a cause |
| pend_any | output | 1 | At least one source pending |
| take_vld | output | 1 | A cause was delivered at the last edge |
| take_onehot | output | N_SRC | Delivered cause, one-hot |
| take_code | output | CODE_W | Delivered cause, encoded |

## Verification
On every cycle the assertions check the following:
- Each delivered cause met its own gate in the cycle it was accepted.
- A delivery is one-hot and agrees with its code.
- Nothing is delivered without accept.
- The level-like sources and any source that was set at its own clear edge are still pending afterwards.

Some things only the bench scenarios can show. One is that the winner really is the highest eligible source. Another is that an ineligible higher source lets a lower one through. A third is that the clear-on-delivery sources leave nothing behind. The bench covers these by sweeping every single source and every pair of sources across all 256 combinations of the control inputs.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int SRC_COUNT = 14;

  localparam int S_SRESET = 0;
  localparam int S_MCHK   = 1;
  localparam int S_DEBUG  = 2;
  localparam int S_HDEC   = 3;
  localparam int S_EXT    = 4;
  localparam int S_CEXT   = 5;
  localparam int S_WDOG   = 6;
  localparam int S_CDBELL = 7;
  localparam int S_FIT    = 8;
  localparam int S_PIT    = 9;
  localparam int S_DEC    = 10;
  localparam int S_DBELL  = 11;
  localparam int S_PERF   = 12;
  localparam int S_THERM  = 13;

  typedef enum logic [2:0] {
    GATE_NONE, GATE_MCHK, GATE_HDEC, GATE_EXT, GATE_CRIT, GATE_LOW
  } gate_cls_e;

  typedef enum logic [1:0] {
    CLR_ON_TAKE, CLR_NEVER, CLR_BY_CFG
  } clr_cls_e;

  typedef struct packed {
    logic ext_en;
    logic mchk_en;
    logic crit_en;
    logic hv_state;
    logic hv_exists;
    logic hdec_enable;
    logic ext_hv_route;
  } state_gate_t;

  function automatic gate_cls_e gate_of(int idx);
    case (idx)
      S_SRESET, S_DEBUG:        return GATE_NONE;
      S_MCHK:                   return GATE_MCHK;
      S_HDEC:                   return GATE_HDEC;
      S_EXT:                    return GATE_EXT;
      S_CEXT, S_WDOG, S_CDBELL: return GATE_CRIT;
      default:                  return GATE_LOW;
    endcase
  endfunction

  function automatic clr_cls_e clr_of(int idx);
    case (idx)
      S_EXT, S_CEXT: return CLR_NEVER;
      S_DEC:         return CLR_BY_CFG;
      default:       return CLR_ON_TAKE;
    endcase
  endfunction

endpackage

// File: rtl/irq_elig.sv
module irq_elig
  import irq_sel_pkg::*;
#(
  parameter int N_SRC = SRC_COUNT
) (
  input  state_gate_t      gate,
  input  logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] elig
);

  logic ext_ok;
  logic hdec_ok;

  // external may bypass ext_en for a guest when not routed to the hypervisor
  assign ext_ok  = gate.ext_en |
                   (gate.hv_exists & ~gate.hv_state & ~gate.ext_hv_route);
  assign hdec_ok = gate.hdec_enable & (gate.ext_en | ~gate.hv_state);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam gate_cls_e CLS = gate_of(i);
    logic cond;
    if (CLS == GATE_NONE) begin : g_none
      assign cond = 1'b1;
    end else if (CLS == GATE_MCHK) begin : g_mchk
      assign cond = gate.mchk_en;
    end else if (CLS == GATE_HDEC) begin : g_hdec
      assign cond = hdec_ok;
    end else if (CLS == GATE_EXT) begin : g_ext
      assign cond = ext_ok;
    end else if (CLS == GATE_CRIT) begin : g_crit
      assign cond = gate.crit_en;
    end else begin : g_low
      assign cond = gate.ext_en;
    end
    assign elig[i] = pend[i] & cond;
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC  = 14,
  parameter int CODE_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  elig,
  output logic [N_SRC-1:0]  grant,
  output logic [CODE_W-1:0] code,
  output logic              any
);

  // scan from the bottom so the lowest index is written last and wins
  always_comb begin
    grant = '0;
    code  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code     = CODE_W'(i);
      end
    end
  end

  assign any = |elig;

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_q
);

  // a set pulse overrides a clear of the same bit on the same edge
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int N_SRC  = SRC_COUNT,
  parameter int CODE_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  set_i,
  input  logic              ext_en,
  input  logic              mchk_en,
  input  logic              crit_en,
  input  logic              hv_state,
  input  logic              hv_exists,
  input  logic              hdec_enable,
  input  logic              ext_hv_route,
  input  logic              dec_clear_cfg,
  input  logic              accept,
  output logic              pend_any,
  output logic              take_vld,
  output logic [N_SRC-1:0]  take_onehot,
  output logic [CODE_W-1:0] take_code
);

  state_gate_t       gate;
  logic [N_SRC-1:0]  pend_q;
  logic [N_SRC-1:0]  elig;
  logic [N_SRC-1:0]  grant;
  logic [CODE_W-1:0] code;
  logic              any_elig;
  logic              fire;
  logic [N_SRC-1:0]  clr_ok;
  logic [N_SRC-1:0]  clr_vec;

  assign gate = '{ext_en:       ext_en,
                  mchk_en:      mchk_en,
                  crit_en:      crit_en,
                  hv_state:     hv_state,
                  hv_exists:    hv_exists,
                  hdec_enable:  hdec_enable,
                  ext_hv_route: ext_hv_route};

  irq_pend_bank #(.N_SRC(N_SRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_i),
    .clr_i  (clr_vec),
    .pend_q (pend_q)
  );

  irq_elig #(.N_SRC(N_SRC)) u_elig (
    .gate (gate),
    .pend (pend_q),
    .elig (elig)
  );

  irq_pick #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_pick (
    .elig  (elig),
    .grant (grant),
    .code  (code),
    .any   (any_elig)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    localparam clr_cls_e POL = clr_of(i);
    if (POL == CLR_ON_TAKE) begin : g_take
      assign clr_ok[i] = 1'b1;
    end else if (POL == CLR_NEVER) begin : g_keep
      assign clr_ok[i] = 1'b0;
    end else begin : g_cfg
      assign clr_ok[i] = dec_clear_cfg;
    end
  end

  assign fire    = accept & any_elig;
  assign clr_vec = fire ? (grant & clr_ok) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_vld    <= 1'b0;
      take_onehot <= '0;
      take_code   <= '0;
    end else begin
      take_vld    <= fire;
      take_onehot <= fire ? grant : '0;
      take_code   <= fire ? code : '0;
    end
  end

  assign pend_any = |pend_q;

endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk
  import irq_sel_pkg::*;
#(
  parameter int N_SRC  = SRC_COUNT,
  parameter int CODE_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  set_i,
  input logic              ext_en,
  input logic              mchk_en,
  input logic              crit_en,
  input logic              hv_state,
  input logic              hv_exists,
  input logic              hdec_enable,
  input logic              ext_hv_route,
  input logic              dec_clear_cfg,
  input logic              accept,
  input logic              pend_any,
  input logic              take_vld,
  input logic [N_SRC-1:0]  take_onehot,
  input logic [CODE_W-1:0] take_code
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!take_vld && !pend_any && take_onehot == '0));

  p_single_cause_r2: assert property (@(posedge clk) disable iff (rst)
    take_vld |-> ($countones(take_onehot) == 1 && take_onehot[take_code]));

  p_mchk_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (take_vld && take_onehot[S_MCHK]) |-> $past(mchk_en));

  p_hdec_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (take_vld && take_onehot[S_HDEC]) |->
      $past(hdec_enable && (ext_en || !hv_state)));

  p_ext_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (take_vld && take_onehot[S_EXT]) |->
      $past(ext_en || (hv_exists && !hv_state && !ext_hv_route)));

  p_ext_stays_r6: assert property (@(posedge clk) disable iff (rst)
    (take_vld && take_onehot[S_EXT]) |-> pend_any);

  p_crit_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (take_vld && |take_onehot[S_CDBELL:S_CEXT]) |-> $past(crit_en));

  p_cext_stays_r7: assert property (@(posedge clk) disable iff (rst)
    (take_vld && take_onehot[S_CEXT]) |-> pend_any);

  p_low_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (take_vld && (|take_onehot[S_PIT:S_FIT] || |take_onehot[S_THERM:S_DBELL]))
      |-> $past(ext_en));

  p_dec_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (take_vld && take_onehot[S_DEC]) |-> $past(ext_en));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (take_vld && |($past(set_i) & take_onehot)) |-> pend_any);

  p_any_after_set_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |$past(set_i)) |-> pend_any);

  p_needs_accept_r12: assert property (@(posedge clk) disable iff (rst)
    take_vld |-> $past(accept));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !take_vld |-> (take_onehot == '0 && take_code == '0));

endmodule

bind irq_prio_sel irq_prio_sel_chk #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/irq_prio_sel_bench.sv
`timescale 1ns/1ps
module irq_prio_sel_bench;

  localparam int N  = 14;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  set_i;
  logic          ext_en, mchk_en, crit_en, hv_state, hv_exists;
  logic          hdec_enable, ext_hv_route, dec_clear_cfg, accept;
  logic          pend_any, take_vld;
  logic [N-1:0]  take_onehot;
  logic [CW-1:0] take_code;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_prio_sel u_irq_prio_sel (
    .clk(clk), .rst(rst), .set_i(set_i), .ext_en(ext_en), .mchk_en(mchk_en),
    .crit_en(crit_en), .hv_state(hv_state), .hv_exists(hv_exists),
    .hdec_enable(hdec_enable), .ext_hv_route(ext_hv_route),
    .dec_clear_cfg(dec_clear_cfg), .accept(accept), .pend_any(pend_any),
    .take_vld(take_vld), .take_onehot(take_onehot), .take_code(take_code)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cfg bits: 0 ext_en, 1 mchk_en, 2 crit_en, 3 hv_state, 4 hv_exists,
  //           5 hdec_enable, 6 ext_hv_route, 7 dec_clear_cfg
  function automatic bit eligible(int s, logic [7:0] c);
    case (s)
      0, 2:    return 1'b1;
      1:       return c[1];
      3:       return c[5] && (c[0] || !c[3]);
      4:       return c[0] || (c[4] && !c[3] && !c[6]);
      5, 6, 7: return c[2];
      default: return c[0];
    endcase
  endfunction

  function automatic bit clears(int s, logic [7:0] c);
    case (s)
      4, 5:    return 1'b0;
      10:      return c[7];
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(int s);
    case (s)
      0, 2:    return "R3";
      1:       return "R4";
      3:       return "R5";
      4:       return "R6";
      5, 6, 7: return "R7";
      10:      return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic apply_cfg(logic [7:0] c);
    ext_en = c[0]; mchk_en = c[1]; crit_en = c[2]; hv_state = c[3];
    hv_exists = c[4]; hdec_enable = c[5]; ext_hv_route = c[6];
    dec_clear_cfg = c[7];
  endtask

  task automatic scenario(logic [N-1:0] bits, logic [7:0] c, bit pair);
    int w;
    logic [N-1:0] remain;
    string tag;
    rst = 1'b1; step(); rst = 1'b0;
    apply_cfg(c);
    set_i = bits; step(); set_i = '0;
    check("R11", "pend_any after set", int'(pend_any), 1);
    accept = 1'b1; step(); accept = 1'b0;
    w = -1;
    for (int s = N - 1; s >= 0; s--)
      if (bits[s] && eligible(s, c)) w = s;
    tag = (w < 0) ? (pair ? "R2" : req_of($clog2(int'(bits)))) :
          (pair ? "R2" : req_of(w));
    check(tag, "take_vld", int'(take_vld), (w >= 0) ? 1 : 0);
    if (w >= 0) begin
      check(tag, "take_code", int'(take_code), w);
      check(tag, "take_onehot", int'(take_onehot), 1 << w);
    end else begin
      check("R12", "take_onehot idle", int'(take_onehot), 0);
    end
    remain = bits;
    if (w >= 0 && clears(w, c)) remain[w] = 1'b0;
    check((w >= 0) ? req_of(w) : "R11", "pend_any after take",
          int'(pend_any), (remain != '0) ? 1 : 0);
    step();
    check("R12", "take_vld without accept", int'(take_vld), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; set_i = '0; accept = 1'b0; apply_cfg(8'h00);
    @(negedge clk); step(); step();
    rst = 1'b0; step();
    check("R1", "pend_any", int'(pend_any), 0);
    check("R1", "take_vld", int'(take_vld), 0);
    check("R1", "take_onehot", int'(take_onehot), 0);
    check("R1", "take_code", int'(take_code), 0);

    // R12: accept with nothing pending delivers nothing
    accept = 1'b1; step(); accept = 1'b0;
    check("R12", "take_vld empty accept", int'(take_vld), 0);

    // R10: watchdog set again on its own clear edge stays pending
    apply_cfg(8'h04);
    set_i = N'(1 << 6); step();
    accept = 1'b1; step();
    set_i = '0; accept = 1'b0;
    check("R10", "take_code", int'(take_code), 6);
    check("R10", "pend_any kept", int'(pend_any), 1);
    accept = 1'b1; step(); accept = 1'b0;
    check("R10", "second take", int'(take_code), 6);
    check("R10", "pend_any cleared", int'(pend_any), 0);

    // every single source across every control combination
    for (int s = 0; s < N; s++)
      for (int c = 0; c < 256; c++)
        scenario(N'(1 << s), 8'(c), 1'b0);

    // every pair of sources across every control combination (R2)
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        for (int c = 0; c < 256; c++)
          scenario(N'((1 << i) | (1 << j)), 8'(c), 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule